// File: doc/BRIEF.md
# Transfer Descriptor Scan Scheduler

This block picks which of a table of host transfer descriptor slots is serviced next. Every slot reports a valid flag. A slot may also carry an enabled next-pointer that names the slot to look at after it. Two registers written through a small write port shape the walk. The skip map removes slots from consideration. The last-slot register shortens the group that is scanned, so a sparsely filled table is walked without touching its empty upper part.

The scheduler presents one slot index together with a valid strobe. It holds that index until the consumer returns a one-cycle done pulse. It then moves on in a single cycle, either in slot order or to the slot named by the serviced descriptor's pointer. The search is circular: past the end of the group it wraps to slot 0. When no slot in the group qualifies, the strobe stays low, and a new search runs every clock until a slot becomes eligible.

Top module: `td_scan_sched`

## Requirements
- R1: While rst_n is low at a clock edge, sel_valid goes low and the skip map, the last-slot register and the scan position are cleared to zero, so the first search after reset starts at slot 0.
- R2: A slot whose skip-map bit is 1 is never presented, even when its valid flag is 1.
- R3: When the presented slot's skip bit is 1 at the cycle done is taken, its next pointer is ignored and the search starts at the following slot.
- R4: Slots above the lowest set bit of the last-slot register are never presented. After that slot the search wraps to slot 0. Only the lowest bit counts when several are set.
- R5: With the last-slot register at zero, all slots from 0 to 31 form the group and the search wraps from 31 to 0.
- R6: Only slots whose slot_valid bit is 1 are presented. Invalid slots are passed over.
- R7: On done, if the presented slot has slot_ptr_en set and is not skipped, the next search starts at its pointer, slot_ptr[idx*5 +: 5].
- R8: If the pointer's target is invalid, skipped or outside the group, the search continues in circular order from the target without stalling.
- R9: While sel_valid is high and done is low, sel_valid and sel_index stay unchanged, whatever happens to the slot inputs.
- R10: When no slot in the group is eligible, sel_valid is low. Once a slot becomes eligible, it is presented one clock later.
- R11: wr_en with wr_sel = 0 loads wr_data into the skip map, and wr_sel = 1 loads it into the last-slot register. A write affects searches from the next clock on.
- R12: On done without a usable pointer, the next search starts at the slot after the presented one. The new slot is presented, or sel_valid drops, on the clock that takes done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 skip map, 1 last-slot |
| wr_data | input | 32 | Register write data, one bit per slot |
| slot_valid | input | 32 | Valid flag of each slot |
| slot_ptr_en | input | 32 | Next-pointer enable of each slot |
| slot_ptr | input | 160 | Next-pointer of each slot, 5 bits per slot, slot i at bits i*5+4..i*5 |
| done | input | 1 | Consumer finished the presented slot |
| sel_valid | output | 1 | A slot is presented |
| sel_index | output | 5 | Index of the presented slot |

## Verification
The bench builds the block with its default parameters: 32 slots and a 5-bit index. At that size the directed cases can reach slot 31 and the wrap from 31 to 0, place the group boundary inside the table with two last-slot bits set, and aim pointers at any slot. A behavioural model runs alongside the directed sequences and a long random phase. That phase mixes one-hot, double-bit and zero last-slot values with random skip maps and pointers, so the model is compared against boundaries at every position.

// File: rtl/td_sched_pkg.sv
// Shared definitions for the transfer descriptor scan scheduler.
// Assumes: only the register select encoding is shared between modules.
package td_sched_pkg;

    // Register select on the write port
    typedef enum logic {
        REG_SKIP = 1'b0,
        REG_LAST = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/td_sched_regs.sv
// Skip map and last-slot register with the derived group mask.
// Function: holds the two software-written slot maps and turns the
//   last-slot value into a mask of slots that belong to the scan group.
// Assumes: synchronous active-low reset; writes land on the next edge.
module td_sched_regs
    import td_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [NUM_SLOTS-1:0] wr_data,
    output logic [NUM_SLOTS-1:0] skip_q,
    output logic [NUM_SLOTS-1:0] last_q,
    output logic [NUM_SLOTS-1:0] grp_mask
);

    // Register write and reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= '0;
            last_q <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == REG_SKIP)
                skip_q <= wr_data;
            else
                last_q <= wr_data;
        end
    end

    // Group mask: a slot is in the group while no last bit lies below it
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            grp_mask[i] = ~seen;
            seen        = seen | last_q[i];
        end
    end

    // R4: the group is contiguous from slot 0
    a_r4_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
        grp_mask[0] && ((grp_mask & (grp_mask + 1'b1)) == '0));

    // R5: an empty last-slot register opens the full table
    a_r5_full_group: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q == '0) |-> (&grp_mask));

endmodule

// File: rtl/td_sched_pick.sv
// Circular first-eligible finder.
// Function: starting at 'start' and wrapping past the top slot, returns
//   the first slot whose eligibility bit is set.
// Assumes: start < NUM_SLOTS; purely combinational.
module td_sched_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] elig,
    input  logic [IDX_W-1:0]     start,
    output logic                 found,
    output logic [IDX_W-1:0]     pick
);

    // Scan offsets from the highest down so the nearest one wins
    always_comb begin
        int slot;
        found = 1'b0;
        pick  = '0;
        for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
            slot = int'(start) + k;
            if (slot >= NUM_SLOTS)
                slot = slot - NUM_SLOTS;
            if (elig[slot]) begin
                found = 1'b1;
                pick  = IDX_W'(slot);
            end
        end
    end

endmodule

// File: rtl/td_sched_next.sv
// Next search start after a slot is finished.
// Function: follows the finished slot's pointer when it is enabled and
//   the slot is not skipped, otherwise steps to the following slot.
// Assumes: pointers are packed IDX_W bits per slot; out-of-range
//   pointers restart the search at slot 0.
module td_sched_next #(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic [IDX_W-1:0]           cur_idx,
    input  logic [NUM_SLOTS-1:0]       skip_q,
    input  logic [NUM_SLOTS-1:0]       ptr_en,
    input  logic [NUM_SLOTS*IDX_W-1:0] ptr_bus,
    output logic [IDX_W-1:0]           next_start
);

    localparam int LAST_IDX = NUM_SLOTS - 1;

    logic [IDX_W-1:0] ptr_val;
    logic [IDX_W-1:0] seq_val;

    // Pointer of the finished slot, clamped to the table
    always_comb begin
        ptr_val = ptr_bus[int'(cur_idx)*IDX_W +: IDX_W];
        if (int'(ptr_val) > LAST_IDX)
            ptr_val = '0;
    end

    // Sequential successor with wrap at the table end
    always_comb begin
        if (int'(cur_idx) == LAST_IDX)
            seq_val = '0;
        else
            seq_val = cur_idx + 1'b1;
    end

    // Choose pointer or successor
    always_comb begin
        if (ptr_en[cur_idx] && !skip_q[cur_idx])
            next_start = ptr_val;
        else
            next_start = seq_val;
    end

endmodule

// File: rtl/td_scan_sched.sv
// Transfer descriptor scan scheduler (top).
// Function: presents the next eligible descriptor slot, holds it until
//   done, then searches again from the successor or the pointer target.
// Assumes: done is a single-cycle pulse; done while idle is ignored;
//   synchronous active-low reset.
module td_scan_sched
    import td_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_sel,
    input  logic [NUM_SLOTS-1:0]       wr_data,
    input  logic [NUM_SLOTS-1:0]       slot_valid,
    input  logic [NUM_SLOTS-1:0]       slot_ptr_en,
    input  logic [NUM_SLOTS*IDX_W-1:0] slot_ptr,
    input  logic                       done,
    output logic                       sel_valid,
    output logic [IDX_W-1:0]           sel_index
);

    logic [NUM_SLOTS-1:0] skip_q;
    logic [NUM_SLOTS-1:0] last_q;
    logic [NUM_SLOTS-1:0] grp_mask;
    logic [NUM_SLOTS-1:0] elig;
    logic [IDX_W-1:0]     cursor_q;
    logic [IDX_W-1:0]     next_start;
    logic [IDX_W-1:0]     search_start;
    logic                 sel_valid_q;
    logic [IDX_W-1:0]     sel_idx_q;
    logic                 found;
    logic [IDX_W-1:0]     pick;
    logic                 advance;

    td_sched_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .skip_q   (skip_q),
        .last_q   (last_q),
        .grp_mask (grp_mask)
    );

    td_sched_next #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_next (
        .cur_idx    (sel_idx_q),
        .skip_q     (skip_q),
        .ptr_en     (slot_ptr_en),
        .ptr_bus    (slot_ptr),
        .next_start (next_start)
    );

    td_sched_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
        .elig  (elig),
        .start (search_start),
        .found (found),
        .pick  (pick)
    );

    // Slots that may be presented this cycle
    assign elig = slot_valid & ~skip_q & grp_mask;

    // A finished slot moves the search on
    assign advance = sel_valid_q && done;

    // Search from the successor on done, else from the held position
    assign search_start = advance ? next_start : cursor_q;

    // Selection state: hold, advance on done, or search while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_q <= 1'b0;
            sel_idx_q   <= '0;
            cursor_q    <= '0;
        end else if (advance) begin
            cursor_q    <= next_start;
            sel_valid_q <= found;
            if (found)
                sel_idx_q <= pick;
        end else if (!sel_valid_q) begin
            sel_valid_q <= found;
            if (found)
                sel_idx_q <= pick;
        end
    end

    assign sel_valid = sel_valid_q;
    assign sel_index = sel_idx_q;

    // R9: a presented slot stays put until done
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_q && !done) |=> (sel_valid_q && $stable(sel_idx_q)));

    // R2: the finder never returns a skipped slot
    a_r2_skip_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !skip_q[pick]);

    // R6: the finder only returns valid slots
    a_r6_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> slot_valid[pick]);

    // R4: the finder stays inside the group
    a_r4_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> grp_mask[pick]);

    // R10: nothing eligible while idle keeps the strobe low
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid_q && !found) |=> !sel_valid_q);

    // R10: an eligible slot while idle is presented on the next edge
    a_r10_idle_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid_q && found) |=> sel_valid_q);

endmodule

// File: tb/td_scan_sched_bench.sv
`timescale 1ns/1ps
module td_scan_sched_bench;

    localparam int N  = 32;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic            wr_sel;
    logic [N-1:0]    wr_data;
    logic [N-1:0]    slot_valid;
    logic [N-1:0]    slot_ptr_en;
    logic [N*IW-1:0] slot_ptr;
    logic            done;
    logic            sel_valid;
    logic [IW-1:0]   sel_index;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit       m_valid;
    int       m_idx;
    int       m_cursor;
    bit [N-1:0] m_skip;
    bit [N-1:0] m_last;

    always #2.5 clk = ~clk;

    td_scan_sched u_td_scan_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .slot_valid (slot_valid),
        .slot_ptr_en(slot_ptr_en),
        .slot_ptr   (slot_ptr),
        .done       (done),
        .sel_valid  (sel_valid),
        .sel_index  (sel_index)
    );

    function automatic bit in_group(int i);
        for (int j = 0; j < i; j++)
            if (m_last[j]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int find_from(int start);
        for (int k = 0; k < N; k++) begin
            int s;
            s = (start + k) % N;
            if (slot_valid[s] && !m_skip[s] && in_group(s)) return s;
        end
        return -1;
    endfunction

    // Reference model step and per-cycle comparison
    always @(posedge clk) begin
        int f;
        int ns;
        if (!rst_n) begin
            m_valid = 0; m_idx = 0; m_cursor = 0; m_skip = '0; m_last = '0;
        end else begin
            if (m_valid && done) begin
                if (slot_ptr_en[m_idx] && !m_skip[m_idx])
                    ns = int'(slot_ptr[m_idx*IW +: IW]);
                else
                    ns = (m_idx + 1) % N;
                m_cursor = ns;
                f = find_from(ns);
                m_valid = (f >= 0);
                if (f >= 0) m_idx = f;
            end else if (!m_valid) begin
                f = find_from(m_cursor);
                m_valid = (f >= 0);
                if (f >= 0) m_idx = f;
            end
            if (wr_en) begin
                if (wr_sel) m_last = wr_data;
                else        m_skip = wr_data;
            end
        end
        #1;
        checks++;
        if (sel_valid !== m_valid || (m_valid && int'(sel_index) != m_idx)) begin
            errors++;
            $display("FAIL %s (model): sel_valid=%0b sel_index=%0d expected %0b/%0d",
                     cur_req, sel_valid, sel_index, m_valid, m_idx);
        end
    end

    task automatic expect_sel(input string req, input bit v, input int idx);
        checks++;
        if (sel_valid !== v || (v && int'(sel_index) != idx)) begin
            errors++;
            $display("FAIL %s: sel_valid=%0b sel_index=%0d expected %0b/%0d",
                     req, sel_valid, sel_index, v, idx);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic write_reg(input bit sel, input logic [N-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ptr(input int slot, input int target);
        slot_ptr[slot*IW +: IW] = IW'(target);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        slot_valid = '0; slot_ptr_en = '0; slot_ptr = '0; done = 1'b0;
        repeat (3) @(negedge clk);
        expect_sel("R1", 0, 0);
        rst_n = 1'b1;
        step();
        expect_sel("R10", 0, 0);

        // R1 R6 R12: sequential walk over sparse valid slots
        cur_req = "R6";
        slot_valid = (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 9);
        step();        expect_sel("R1", 1, 3);
        pulse_done();  expect_sel("R12", 1, 7);
        pulse_done();  expect_sel("R12", 1, 9);
        pulse_done();  expect_sel("R5", 1, 3);

        // R9: hold without done, even when inputs move
        cur_req = "R9";
        step(); step(); step();
        expect_sel("R9", 1, 3);
        slot_valid[0] = 1'b1;
        step();        expect_sel("R9", 1, 3);
        pulse_done();  expect_sel("R12", 1, 7);

        // R2 R11: skip map hides a valid slot
        cur_req = "R2";
        write_reg(1'b0, 32'd1 << 9);
        expect_sel("R9", 1, 7);
        pulse_done();  expect_sel("R2", 1, 0);

        // R4: two last bits, the lower one bounds the group at 4
        cur_req = "R4";
        write_reg(1'b1, (32'd1 << 4) | (32'd1 << 20));
        pulse_done();  expect_sel("R4", 1, 3);
        pulse_done();  expect_sel("R4", 1, 0);

        // R5: full table, wrap from 31
        cur_req = "R5";
        write_reg(1'b1, '0);
        write_reg(1'b0, '0);
        slot_valid = (32'd1 << 31) | 32'd1;
        pulse_done();  expect_sel("R5", 1, 31);
        pulse_done();  expect_sel("R5", 1, 0);

        // R7: pointer jumps over slot 5
        cur_req = "R7";
        slot_valid = (32'd1 << 1) | (32'd1 << 5) | (32'd1 << 20);
        slot_ptr_en[1] = 1'b1; set_ptr(1, 20);
        pulse_done();  expect_sel("R6", 1, 1);
        pulse_done();  expect_sel("R7", 1, 20);
        pulse_done();  expect_sel("R7", 1, 1);

        // R8: pointer to an invalid slot, then to a skipped slot
        cur_req = "R8";
        set_ptr(1, 12);
        slot_valid[14] = 1'b1;
        pulse_done();  expect_sel("R8", 1, 14);
        set_ptr(1, 14);
        write_reg(1'b0, 32'd1 << 14);
        pulse_done();  expect_sel("R8", 1, 20);
        pulse_done();  expect_sel("R8", 1, 1);
        pulse_done();  expect_sel("R8", 1, 20);

        // R3: skipped slot's own pointer is ignored
        cur_req = "R3";
        slot_ptr_en[20] = 1'b1; set_ptr(20, 5);
        write_reg(1'b0, 32'd1 << 20);
        pulse_done();  expect_sel("R3", 1, 1);

        // R10: nothing eligible, then one slot appears
        cur_req = "R10";
        slot_ptr_en = '0; slot_valid = '0;
        pulse_done();  expect_sel("R10", 0, 0);
        step(); step(); expect_sel("R10", 0, 0);
        slot_valid = 32'd1 << 6;
        step();        expect_sel("R10", 1, 6);

        // R1: reset mid-run clears the skip map
        cur_req = "R1";
        write_reg(1'b0, 32'd1 << 6);
        rst_n = 1'b0;
        step();        expect_sel("R1", 0, 0);
        rst_n = 1'b1;
        step();        expect_sel("R1", 1, 6);

        // Random phase against the model (R11 R12 and all orderings)
        cur_req = "R12";
        for (int c = 0; c < 4000; c++) begin
            slot_valid = $urandom() & $urandom();
            done = ($urandom_range(1) == 1);
            if ($urandom_range(3) == 0) begin
                slot_ptr_en = $urandom();
                for (int s = 0; s < N; s++) set_ptr(s, $urandom_range(N - 1));
            end
            wr_en = ($urandom_range(15) == 0);
            wr_sel = $urandom_range(1);
            if (wr_sel) begin
                case ($urandom_range(2))
                    0: wr_data = '0;
                    1: wr_data = 32'd1 << $urandom_range(N - 1);
                    default: wr_data = (32'd1 << $urandom_range(N - 1)) |
                                       (32'd1 << $urandom_range(N - 1));
                endcase
            end else begin
                wr_data = $urandom() & $urandom() & $urandom();
            end
            @(negedge clk);
        end
        wr_en = 1'b0; done = 1'b0;
        step();
        finish_run();
    end

endmodule